// File: doc/BRIEF.md
# Overcurrent Fault Latch Manager

This block sits between a digital overcurrent comparator, a low-side supply-good flag and the gate controller of a three-phase bridge. It filters the comparator through a blanking window, turns a qualified trip or a supply dropout into a latched global shutdown for all six gate drivers, and drives an active-low fault flag meant to control an open-drain pad.

A latched fault releases by itself once the gate controller has held every low-side command inactive for a programmed number of consecutive cycles. A parameter chooses a variant in which the high-side commands must also be held inactive. The clear interval only counts while the supply is good and no qualified trip is present. Blanking, indication delay, shutdown delay and clear interval are all parameters in clock cycles.

The controller is a three-state machine:
- `ST_RUN` (no fault) goes to `ST_PEND` on a qualified trip, or straight to `ST_HOLD` on a supply dropout.
- `ST_PEND` (trip delay running) goes to `ST_HOLD` when the longer of the two delays has elapsed, or at once on a supply dropout.
- `ST_HOLD` (fault latched) goes back to `ST_RUN` when the clear interval completes.

Top module: `ocp_fault_mgr`

## Requirements
- R1: After reset `shutdown_o` is 0 and `fault_n_o` is 1.
- R2: A trip input that is high for fewer than `BLANK_CYC` consecutive clock edges has no effect on either output.
- R3: When the trip input is sampled high on `BLANK_CYC` consecutive edges, counting the first such edge as edge 1:
  - `fault_n_o` goes low after edge `BLANK_CYC+1+FLT_DLY`.
  - `shutdown_o` goes high after edge `BLANK_CYC+1+SHDN_DLY`.
- R4: Once asserted, `shutdown_o` and `fault_n_o` stay in the fault state after the trip input returns low, until the clear condition of R5 is met.
- R5: In `ST_HOLD` the fault releases after `CLR_CYC` consecutive quiet edges. An edge is quiet when all three conditions hold:
  - every bit of `lo_cmd_i` is 0 (1 means the command is active);
  - `vcc_ok_i` is 1;
  - no qualified trip is present.
- R6: Any active low-side command during the clear interval restarts the count from zero, so a new full `CLR_CYC` run is needed.
- R7: With `HI_GATES_CLEAR=1`, an active bit of `hi_cmd_i` also restarts the clear count. With `HI_GATES_CLEAR=0`, `hi_cmd_i` has no effect.
- R8: `vcc_ok_i` at 0 forces both outputs into the fault state after the next edge, with no blanking. The clear count stays at zero until `vcc_ok_i` returns to 1.
- R9: A qualified trip present in the cycle in which the clear interval would complete prevents the release, and the count restarts.
- R10: `shutdown_o` falls in the same cycle in which `fault_n_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_raw_i | input | 1 | Overcurrent comparator output, high = over limit |
| vcc_ok_i | input | 1 | Low-side supply good, 0 = undervoltage |
| lo_cmd_i | input | NCH | Low-side gate commands, 1 = active |
| hi_cmd_i | input | NCH | High-side gate commands, 1 = active |
| shutdown_o | output | 1 | Global turn-off to the gate controller, 1 = all drivers off |
| fault_n_o | output | 1 | Fault flag, 0 = fault (pad pull-down enabled) |

## Verification
Two functions can land in the same cycle: completion of the clear interval and qualification of a fresh trip. The bench starts a second trip burst so that its `BLANK_CYC`-th sample falls exactly in the cycle in which the hold would otherwise end. It then checks that both outputs stay in the fault state and that the release moves a full `CLR_CYC` interval later. A second pair of concurrent events is a low-side command pulse landing mid-interval. The bench runs this on two instances that differ only in the high-side variant, so the same high-side pulse yields two different release cycles.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PEND = 2'd1,
        ST_HOLD = 2'd2
    } ocp_state_e;

    function automatic int unsigned ocp_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ocp_trip_blanker.sv
module ocp_trip_blanker #(
    parameter int unsigned BLANK_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_raw_i,
    output logic trip_qual_o
);
    localparam int unsigned CW = $clog2(BLANK_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(BLANK_CYC);

    logic [CW-1:0] run_q;

    // consecutive-high counter, saturating at the blanking length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!trip_raw_i) begin
            run_q <= '0;
        end else if (run_q != LIM) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign trip_qual_o = (run_q == LIM);

    AST_QUAL_FOLLOWS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        trip_qual_o |-> $past(trip_raw_i)); // R2

endmodule

// File: rtl/ocp_span_counter.sv
module ocp_span_counter #(
    parameter int unsigned LIMIT = 4,
    localparam int unsigned W = $clog2(LIMIT + 2)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    output logic [W-1:0] count_o,
    output logic         done_o
);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (!run_i) begin
            count_o <= '0;
        end else if (count_o != LIM) begin
            count_o <= count_o + 1'b1;
        end
    end

    assign done_o = (count_o == LIM);

endmodule

// File: rtl/ocp_fault_mgr.sv
module ocp_fault_mgr
    import ocp_pkg::*;
#(
    parameter int unsigned NCH            = 3,
    parameter int unsigned BLANK_CYC      = 40,
    parameter int unsigned FLT_DLY        = 14,
    parameter int unsigned SHDN_DLY       = 25,
    parameter int unsigned CLR_CYC        = 850000,
    parameter bit          HI_GATES_CLEAR = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           trip_raw_i,
    input  logic           vcc_ok_i,
    input  logic [NCH-1:0] lo_cmd_i,
    input  logic [NCH-1:0] hi_cmd_i,
    output logic           shutdown_o,
    output logic           fault_n_o
);
    localparam int unsigned PEND_LAST = ocp_max(FLT_DLY, SHDN_DLY);
    localparam int unsigned PW        = $clog2(PEND_LAST + 2);
    localparam int unsigned CLW       = $clog2(CLR_CYC + 1);
    localparam logic [PW-1:0]  SHDN_AT = PW'(SHDN_DLY);
    localparam logic [PW-1:0]  FLT_AT  = PW'(FLT_DLY);
    localparam logic [NCH-1:0] HI_MASK = {NCH{HI_GATES_CLEAR}};

    ocp_state_e     state_q, state_d;
    logic           trip_qual;
    logic           quiet;
    logic [PW-1:0]  pend_cnt;
    logic           pend_done;
    logic [CLW-1:0] clr_cnt;
    logic           clr_done;

    ocp_trip_blanker #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk         (clk),
        .rst_n       (rst_n),
        .trip_raw_i  (trip_raw_i),
        .trip_qual_o (trip_qual)
    );

    // delay from qualified trip to indication and turn-off
    ocp_span_counter #(.LIMIT(PEND_LAST)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (state_q == ST_PEND),
        .count_o (pend_cnt),
        .done_o  (pend_done)
    );

    // clear interval: counts consecutive quiet edges while latched
    assign quiet = vcc_ok_i && !trip_qual && (lo_cmd_i == '0)
                   && ((hi_cmd_i & HI_MASK) == '0);

    ocp_span_counter #(.LIMIT(CLR_CYC - 1)) u_clr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   ((state_q == ST_HOLD) && quiet),
        .count_o (clr_cnt),
        .done_o  (clr_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (!vcc_ok_i)      state_d = ST_HOLD;
                else if (trip_qual) state_d = ST_PEND;
            end
            ST_PEND: begin
                if (!vcc_ok_i || pend_done) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (quiet && clr_done) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        shutdown_o = 1'b0;
        fault_n_o  = 1'b1;
        unique case (state_q)
            ST_RUN: begin
                shutdown_o = 1'b0;
                fault_n_o  = 1'b1;
            end
            ST_PEND: begin
                shutdown_o = (pend_cnt >= SHDN_AT);
                fault_n_o  = !(pend_cnt >= FLT_AT);
            end
            ST_HOLD: begin
                shutdown_o = 1'b1;
                fault_n_o  = 1'b0;
            end
            default: begin
                shutdown_o = 1'b0;
                fault_n_o  = 1'b1;
            end
        endcase
    end

    AST_UV_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok_i |=> shutdown_o); // R8
    AST_RELEASE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shutdown_o) |-> $rose(fault_n_o)); // R10
    AST_RELEASE_LO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shutdown_o) |-> ($past(lo_cmd_i) == '0)); // R5
    AST_LO_CMD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_o && (lo_cmd_i != '0)) |=> shutdown_o); // R6
    AST_HI_CMD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (HI_GATES_CLEAR && shutdown_o && (hi_cmd_i != '0)) |=> shutdown_o); // R7
    AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_o && trip_qual) |=> shutdown_o); // R9

endmodule

// File: tb/ocp_fault_mgr_tb.sv
`timescale 1ns/1ps
module ocp_fault_mgr_tb;

    localparam int NCH = 3;
    localparam int BLANK = 4;
    localparam int FLT = 4;
    localparam int SHDN = 5;
    localparam int CLR = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trip_raw = 1'b0;
    logic vcc_ok = 1'b1;
    logic [NCH-1:0] lo_cmd = '0;
    logic [NCH-1:0] hi_cmd = '0;
    logic sd_a, fn_a, sd_b, fn_b;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        bit    chk;
        logic  sd_a, fn_a, sd_b, fn_b;
        string tag;
    } item_t;

    item_t sb[$];

    always #2 clk = ~clk;

    ocp_fault_mgr #(.NCH(NCH), .BLANK_CYC(BLANK), .FLT_DLY(FLT), .SHDN_DLY(SHDN),
                    .CLR_CYC(CLR), .HI_GATES_CLEAR(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .trip_raw_i(trip_raw), .vcc_ok_i(vcc_ok),
        .lo_cmd_i(lo_cmd), .hi_cmd_i(hi_cmd), .shutdown_o(sd_a), .fault_n_o(fn_a));

    ocp_fault_mgr #(.NCH(NCH), .BLANK_CYC(BLANK), .FLT_DLY(FLT), .SHDN_DLY(SHDN),
                    .CLR_CYC(CLR), .HI_GATES_CLEAR(1'b1)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .trip_raw_i(trip_raw), .vcc_ok_i(vcc_ok),
        .lo_cmd_i(lo_cmd), .hi_cmd_i(hi_cmd), .shutdown_o(sd_b), .fault_n_o(fn_b));

    // monitor: each item describes outputs right after the next rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                if (it.chk) begin
                    checks++;
                    if (sd_a !== it.sd_a || fn_a !== it.fn_a) begin
                        fails++;
                        $display("FAIL %s u_dut: sd=%0b fn=%0b expected sd=%0b fn=%0b",
                                 it.tag, sd_a, fn_a, it.sd_a, it.fn_a);
                    end
                    checks++;
                    if (sd_b !== it.sd_b || fn_b !== it.fn_b) begin
                        fails++;
                        $display("FAIL %s u_dut_hi: sd=%0b fn=%0b expected sd=%0b fn=%0b",
                                 it.tag, sd_b, fn_b, it.sd_b, it.fn_b);
                    end
                end
            end
        end
    end

    task automatic step(input logic tr, input logic vok, input logic [NCH-1:0] lo,
                        input logic [NCH-1:0] hi, input bit chk,
                        input logic esa, input logic efa, input logic esb, input logic efb,
                        input string tag);
        item_t it;
        @(negedge clk);
        trip_raw = tr;
        vcc_ok = vok;
        lo_cmd = lo;
        hi_cmd = hi;
        it.chk = chk;
        it.sd_a = esa; it.fn_a = efa; it.sd_b = esb; it.fn_b = efb;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++)
            step(1'b0, 1'b1, '0, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, tag);
    endtask

    // one scenario; step i is sampled at rising edge i+1
    task automatic run_case(input string tag, input int n,
                            input int t_on, input int t_off, input int t2_on, input int t2_off,
                            input int uv_to, input int lo_at, input int hi_at,
                            input int fn_at, input int sd_at, input int rel_a, input int rel_b);
        for (int i = 0; i < n; i++) begin
            logic tr, vok;
            logic [NCH-1:0] lo, hi;
            tr  = (i >= t_on && i < t_off) || (i >= t2_on && i < t2_off);
            vok = !(i < uv_to);
            lo  = (i == lo_at) ? 3'b010 : 3'b000;
            hi  = (i == hi_at) ? 3'b001 : 3'b000;
            step(tr, vok, lo, hi, 1'b1,
                 (i >= sd_at && i < rel_a), !(i >= fn_at && i < rel_a),
                 (i >= sd_at && i < rel_b), !(i >= fn_at && i < rel_b), tag);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        idle(4, "R1 reset state");
        // short trip of BLANK-1 samples is blanked
        run_case("R2 blanked pulse", 15, 0, 3, -1, -1, 0, -1, -1, 1000, 1000, 0, 0);
        idle(3, "R2 idle");
        // full trip: fault at step 8, shutdown at step 9, release after CLR quiet edges
        run_case("R3/R4/R5/R10 trip latch and clear", 34, 0, 4, -1, -1, 0, -1, -1, 8, 9, 30, 30);
        idle(3, "R5 idle");
        // low-side command pulse restarts the clear interval
        run_case("R6 lo command restart", 44, 0, 4, -1, -1, 0, 20, -1, 8, 9, 40, 40);
        idle(3, "R6 idle");
        // high-side pulse matters only for the variant that gates on it
        run_case("R7 hi command variant", 44, 0, 4, -1, -1, 0, -1, 20, 8, 9, 30, 40);
        idle(3, "R7 idle");
        // supply dropout: immediate fault, count held while supply low
        run_case("R8 undervoltage", 28, -1, -1, -1, -1, 5, -1, -1, 0, 0, 24, 24);
        idle(3, "R8 idle");
        // new trip qualifies exactly in the cycle the release would happen
        run_case("R9 trip at release edge", 54, 0, 4, 26, 30, 0, -1, -1, 8, 9, 50, 50);
        idle(3, "R9 idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule